// File: doc/BRIEF.md
# Write-Decoupling Store Buffer with Enable-Paced Drain

This block sits between a core that can produce one write per core clock and an external bus that advances only on core clock edges where a bus-enable input is high, which gives a bus rate of one half or one quarter of the core clock. Single-word stores go into a small circular queue. A whole evicted cache line goes into a separate one-entry line holder. Both are drained one transfer at a time over a request/acknowledge bus interface.

Writes keep their program order. An evicted line that is still pending leaves before any queued store that falls in the same line. A read-address comparator raises a hazard flag while a matching store or line is still waiting to go out. When a holder is full, the core sees a stall, keeps its request asserted, and the write is taken as soon as space frees up.

Top module: `sbuf_top`

## Requirements
- R1: The store queue holds up to DEPTH (default 4) entries, each with a 32-bit byte address, 32-bit data and 4 byte enables. Four writes are accepted while nothing drains.
- R2: While the queue has space, a write presented with `wr_valid` is accepted on every core clock edge, whether or not `bus_en` is high on that edge.
- R3: `wr_stall` is high exactly when the queue holds DEPTH entries. A write held on the inputs during a stall is accepted once, after space frees, and it is neither lost nor duplicated.
- R4: The line holder keeps one 16-byte (128-bit) line with its address. `ev_full` is high while a line is held. A second eviction offered meanwhile is held on its inputs until the first line has been acknowledged.
- R5: `bus_req` and the choice of source change only on core clock edges where `bus_en` is high. The drain is correct with enable every second cycle and with enable every fourth cycle.
- R6: Once `bus_req` is high, it stays high with stable `bus_addr`, `bus_is_line` and data until `bus_ack` is sampled high on an edge with `bus_en` high. An acknowledge on an edge with `bus_en` low has no effect.
- R7: Queued stores appear on the bus in the order they were accepted.
- R8: When a held line's address bits [31:4] equal those of any queued store, the line is issued first. Otherwise, with the default ordering mode (ORDER_MODE=1), queued stores go first and the line is issued once the queue is empty. `bus_is_line` is 1 for a line transfer and 0 for a word transfer.
- R9: `rd_hazard` is high while `rd_addr[31:2]` equals the address of a pending store, or `rd_addr[31:4]` equals a held line's address. It drops once the matching entry's transfer has been acknowledged.
- R10: After reset, `bus_req`, `wr_stall`, `ev_full` and `rd_hazard` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Core presents a single store |
| wr_addr | input | 32 | Store byte address |
| wr_data | input | 32 | Store data |
| wr_be | input | 4 | Store byte enables |
| wr_stall | output | 1 | Queue full; store is not taken this cycle |
| ev_valid | input | 1 | Evicted line presented |
| ev_addr | input | 32 | Evicted line base address |
| ev_data | input | 128 | Evicted line contents |
| ev_full | output | 1 | Line holder occupied; eviction not taken |
| rd_addr | input | 32 | Read address to check for hazards |
| rd_hazard | output | 1 | Read overlaps a pending store or line |
| bus_en | input | 1 | Bus-side clock enable |
| bus_req | output | 1 | Transfer requested |
| bus_is_line | output | 1 | 1: line transfer, 0: word transfer |
| bus_addr | output | 32 | Transfer address |
| bus_data | output | 32 | Word transfer data |
| bus_be | output | 4 | Word byte enables (all ones for a line) |
| bus_line | output | 128 | Line transfer data |
| bus_ack | input | 1 | Bus accepts the current transfer |

## Verification
The drain is driven with four enable patterns: always off, which fills the queue and holds a stalled write; every fourth edge; every second edge; and an acknowledge that arrives on disabled edges. Together they separate a design that advances on any edge from one that waits for the enable. A line that shares its address with a queued store and a line that shares nothing are run against the same store mix, which shows whether the conflict rule, and not a fixed priority, decides the order. Word-granular and line-granular hazard probes are taken before and after draining, to show that the hazard clears exactly when the matching entry leaves.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   // Source of the transfer currently owning the bus side
   typedef enum logic {
      SRC_WORD = 1'b0,
      SRC_LINE = 1'b1
   } sbuf_src_e;

   // Ordering policy between queued stores and the held line
   localparam int ORD_LINE_FIRST  = 0;
   localparam int ORD_CONFLICT    = 1;
endpackage

// File: rtl/sbuf_word_queue.sv
module sbuf_word_queue #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   parameter int WOFF  = 2,
   parameter int LOFF  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [AW-1:0]     enq_addr,
   input  logic [DW-1:0]     enq_data,
   input  logic [DW/8-1:0]   enq_be,
   output logic              full,
   input  logic              deq,
   output logic              nonempty,
   output logic [AW-1:0]     head_addr,
   output logic [DW-1:0]     head_data,
   output logic [DW/8-1:0]   head_be,
   input  logic [AW-1:0]     probe_addr,
   output logic              probe_word_hit,
   input  logic [AW-1:0]     cmp_line_addr,
   output logic              cmp_line_hit
);
   localparam int BEW = DW / 8;
   localparam int PW  = $clog2(DEPTH);
   localparam int CW  = $clog2(DEPTH + 1);

   logic [AW-1:0]  addr_q [DEPTH];
   logic [DW-1:0]  data_q [DEPTH];
   logic [BEW-1:0] be_q   [DEPTH];
   logic [PW-1:0]  head_q;
   logic [PW-1:0]  tail_q;
   logic [CW-1:0]  cnt_q;
   logic           enq_ok;

   logic [DEPTH-1:0] live;
   logic [DEPTH-1:0] word_match;
   logic [DEPTH-1:0] line_match;

   assign full     = (cnt_q == CW'(DEPTH));
   assign nonempty = (cnt_q != '0);
   assign enq_ok   = enq_valid && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (enq_ok) begin
            tail_q <= tail_q + PW'(1);
         end
         if (deq) begin
            head_q <= head_q + PW'(1);
         end
         cnt_q <= cnt_q + CW'(enq_ok) - CW'(deq);
      end
   end

   // Payload storage carries no reset; validity comes from the pointers
   always_ff @(posedge clk) begin
      if (enq_ok) begin
         addr_q[tail_q] <= enq_addr;
         data_q[tail_q] <= enq_data;
         be_q[tail_q]   <= enq_be;
      end
   end

   assign head_addr = addr_q[head_q];
   assign head_data = data_q[head_q];
   assign head_be   = be_q[head_q];

   // Per-entry occupancy and address comparators
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PW-1:0] rel;
      assign rel           = PW'(i) - head_q;
      assign live[i]       = (CW'(rel) < cnt_q);
      assign word_match[i] = live[i] &&
                             ((addr_q[i] >> WOFF) == (probe_addr >> WOFF));
      assign line_match[i] = live[i] &&
                             ((addr_q[i] >> LOFF) == (cmp_line_addr >> LOFF));
   end

   assign probe_word_hit = |word_match;
   assign cmp_line_hit   = |line_match;
endmodule

// File: rtl/sbuf_line_holder.sv
module sbuf_line_holder #(
   parameter int AW     = 32,
   parameter int LINE_W = 128,
   parameter int LOFF   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [AW-1:0]     load_addr,
   input  logic [LINE_W-1:0] load_data,
   input  logic              pop,
   output logic              held,
   output logic [AW-1:0]     line_addr,
   output logic [LINE_W-1:0] line_data,
   input  logic [AW-1:0]     probe_addr,
   output logic              probe_line_hit
);
   logic              held_q;
   logic [AW-1:0]     addr_q;
   logic [LINE_W-1:0] data_q;
   logic              take;

   assign take = load_valid && !held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
      end else if (take) begin
         held_q <= 1'b1;
      end else if (pop) begin
         held_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         addr_q <= load_addr;
         data_q <= load_data;
      end
   end

   assign held           = held_q;
   assign line_addr      = addr_q;
   assign line_data      = data_q;
   assign probe_line_hit = held_q && ((addr_q >> LOFF) == (probe_addr >> LOFF));
endmodule

// File: rtl/sbuf_drain_ctl.sv
module sbuf_drain_ctl
   import sbuf_pkg::*;
#(
   parameter int ORDER_MODE = ORD_CONFLICT
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bus_en,
   input  logic      word_pend,
   input  logic      line_pend,
   input  logic      line_conflict,
   input  logic      bus_ack,
   output logic      busy,
   output sbuf_src_e src,
   output logic      pop_word,
   output logic      pop_line
);
   logic      busy_q;
   sbuf_src_e src_q;
   logic      pick_line;
   logic      done;

   // Policy variant chosen at elaboration
   if (ORDER_MODE == ORD_LINE_FIRST) begin : g_line_first
      assign pick_line = line_pend;
   end else begin : g_conflict
      assign pick_line = line_pend && (line_conflict || !word_pend);
   end

   assign done = bus_en && busy_q && bus_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         src_q  <= SRC_WORD;
      end else if (bus_en) begin
         if (busy_q) begin
            if (bus_ack) begin
               busy_q <= 1'b0;
            end
         end else if (word_pend || line_pend) begin
            busy_q <= 1'b1;
            src_q  <= pick_line ? SRC_LINE : SRC_WORD;
         end
      end
   end

   assign busy     = busy_q;
   assign src      = src_q;
   assign pop_word = done && (src_q == SRC_WORD);
   assign pop_line = done && (src_q == SRC_LINE);
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
   import sbuf_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int DEPTH      = 4,
   parameter int LINE_BYTES = 16,
   parameter int ORDER_MODE = ORD_CONFLICT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_valid,
   input  logic [AW-1:0]           wr_addr,
   input  logic [DW-1:0]           wr_data,
   input  logic [DW/8-1:0]         wr_be,
   output logic                    wr_stall,
   input  logic                    ev_valid,
   input  logic [AW-1:0]           ev_addr,
   input  logic [LINE_BYTES*8-1:0] ev_data,
   output logic                    ev_full,
   input  logic [AW-1:0]           rd_addr,
   output logic                    rd_hazard,
   input  logic                    bus_en,
   output logic                    bus_req,
   output logic                    bus_is_line,
   output logic [AW-1:0]           bus_addr,
   output logic [DW-1:0]           bus_data,
   output logic [DW/8-1:0]         bus_be,
   output logic [LINE_BYTES*8-1:0] bus_line,
   input  logic                    bus_ack
);
   localparam int BEW    = DW / 8;
   localparam int WOFF   = $clog2(BEW);
   localparam int LOFF   = $clog2(LINE_BYTES);
   localparam int LINE_W = LINE_BYTES * 8;

   // Elaboration-time parameter checks
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("sbuf_top: DW must be a positive multiple of 8");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sbuf_top: DEPTH must be a power of two, at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < BEW) begin : g_bad_line
      $error("sbuf_top: LINE_BYTES must be a power of two no smaller than a word");
   end
   if (ORDER_MODE != ORD_LINE_FIRST && ORDER_MODE != ORD_CONFLICT) begin : g_bad_mode
      $error("sbuf_top: unknown ORDER_MODE");
   end

   logic              q_full;
   logic              q_nonempty;
   logic              q_pop;
   logic [AW-1:0]     q_addr;
   logic [DW-1:0]     q_data;
   logic [BEW-1:0]    q_be;
   logic              q_word_hit;
   logic              q_line_hit;

   logic              l_held;
   logic              l_pop;
   logic [AW-1:0]     l_addr;
   logic [LINE_W-1:0] l_data;
   logic              l_hit;

   logic              d_busy;
   sbuf_src_e         d_src;

   sbuf_word_queue #(
      .AW(AW), .DW(DW), .DEPTH(DEPTH), .WOFF(WOFF), .LOFF(LOFF)
   ) u_queue (
      .clk            (clk),
      .rst_n          (rst_n),
      .enq_valid      (wr_valid),
      .enq_addr       (wr_addr),
      .enq_data       (wr_data),
      .enq_be         (wr_be),
      .full           (q_full),
      .deq            (q_pop),
      .nonempty       (q_nonempty),
      .head_addr      (q_addr),
      .head_data      (q_data),
      .head_be        (q_be),
      .probe_addr     (rd_addr),
      .probe_word_hit (q_word_hit),
      .cmp_line_addr  (l_addr),
      .cmp_line_hit   (q_line_hit)
   );

   sbuf_line_holder #(
      .AW(AW), .LINE_W(LINE_W), .LOFF(LOFF)
   ) u_line (
      .clk            (clk),
      .rst_n          (rst_n),
      .load_valid     (ev_valid),
      .load_addr      (ev_addr),
      .load_data      (ev_data),
      .pop            (l_pop),
      .held           (l_held),
      .line_addr      (l_addr),
      .line_data      (l_data),
      .probe_addr     (rd_addr),
      .probe_line_hit (l_hit)
   );

   sbuf_drain_ctl #(
      .ORDER_MODE(ORDER_MODE)
   ) u_drain (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_en        (bus_en),
      .word_pend     (q_nonempty),
      .line_pend     (l_held),
      .line_conflict (l_held && q_line_hit),
      .bus_ack       (bus_ack),
      .busy          (d_busy),
      .src           (d_src),
      .pop_word      (q_pop),
      .pop_line      (l_pop)
   );

   assign wr_stall    = q_full;
   assign ev_full     = l_held;
   assign rd_hazard   = q_word_hit || l_hit;

   assign bus_req     = d_busy;
   assign bus_is_line = (d_src == SRC_LINE);
   assign bus_addr    = (d_src == SRC_LINE) ? l_addr : q_addr;
   assign bus_data    = q_data;
   assign bus_be      = (d_src == SRC_LINE) ? {BEW{1'b1}} : q_be;
   assign bus_line    = l_data;
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk #(
   parameter int AW         = 32,
   parameter int DEPTH      = 4,
   parameter int LINE_BYTES = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wr_stall,
   input logic          ev_valid,
   input logic [AW-1:0] ev_addr,
   input logic          ev_full,
   input logic [AW-1:0] rd_addr,
   input logic          rd_hazard,
   input logic          bus_en,
   input logic          bus_req,
   input logic          bus_is_line,
   input logic [AW-1:0] bus_addr,
   input logic          bus_ack
);
   localparam int LOFF = $clog2(LINE_BYTES);
   localparam int OW   = $clog2(DEPTH + 2);

   logic [OW-1:0] occ_q;
   logic [AW-1:0] held_line_q;
   logic          word_done;

   assign word_done = bus_en && bus_req && bus_ack && !bus_is_line;

   // Independent occupancy model built only from port handshakes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q       <= '0;
         held_line_q <= '0;
      end else begin
         occ_q <= occ_q + OW'(wr_valid && !wr_stall) - OW'(word_done);
         if (ev_valid && !ev_full) begin
            held_line_q <= ev_addr >> LOFF;
         end
      end
   end

   a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OW'(DEPTH));

   a_r3_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stall == (occ_q == OW'(DEPTH)));

   a_r4_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ev_full && !(bus_en && bus_req && bus_ack && bus_is_line) |=> ev_full);

   a_r5_req_only_on_en: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |=> $stable(bus_req));

   a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !(bus_en && bus_ack) |=>
         bus_req && $stable(bus_addr) && $stable(bus_is_line));

   a_r8_line_before_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) && !bus_is_line && $past(ev_full) |->
         (bus_addr >> LOFF) != held_line_q);

   a_r9_line_hazard: assert property (@(posedge clk) disable iff (!rst_n)
      ev_full && ((rd_addr >> LOFF) == held_line_q) |-> rd_hazard);
endmodule

bind sbuf_top sbuf_chk #(
   .AW(AW), .DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/sim_sbuf_top.sv
module sim_sbuf_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic [31:0]  wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [3:0]   wr_be = '0;
   logic         wr_stall;
   logic         ev_valid = 1'b0;
   logic [31:0]  ev_addr = '0;
   logic [127:0] ev_data = '0;
   logic         ev_full;
   logic [31:0]  rd_addr = '0;
   logic         rd_hazard;
   logic         bus_en = 1'b0;
   logic         bus_req;
   logic         bus_is_line;
   logic [31:0]  bus_addr;
   logic [31:0]  bus_data;
   logic [3:0]   bus_be;
   logic [127:0] bus_line;
   logic         bus_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   int en_div = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic         is_line;
      logic [31:0]  addr;
      logic [127:0] data;
      logic [3:0]   be;
   } item_t;
   item_t sb[$];
   string sb_tag[$];

   always #5 clk = ~clk;

   sbuf_top u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_word(input logic [31:0] a, input logic [31:0] d,
                              input logic [3:0] be, input string tag);
      sb.push_back({1'b0, a, {96'b0, d}, be});
      sb_tag.push_back(tag);
   endtask

   task automatic expect_line(input logic [31:0] a, input logic [127:0] d,
                              input string tag);
      sb.push_back({1'b1, a, d, 4'hF});
      sb_tag.push_back(tag);
   endtask

   // Driver: presents a store, holds it through stalls, returns after the accepting edge
   task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] be, input bit track);
      wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      while (wr_stall) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      if (track) expect_word(a, d, be, "R7");
   endtask

   task automatic do_evict(input logic [31:0] a, input logic [127:0] d);
      ev_valid = 1'b1; ev_addr = a; ev_data = d;
      while (ev_full) @(negedge clk);
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic drain_wait();
      while (sb.size() != 0 || bus_req) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // Bus responder and monitor: enable pattern, acknowledge, scoreboard compare
   int unsigned phase = 0;
   int unsigned wait_cnt = 0;
   int unsigned lat = 1;
   bit ign_pending = 1'b0;
   logic [31:0] ign_addr = '0;
   always @(negedge clk) begin
      if (ign_pending) begin
         chk(bus_req && bus_addr == ign_addr, "R6 ignored ack", {96'b0, bus_addr},
             {96'b0, ign_addr});
         ign_pending = 1'b0;
      end
      phase++;
      bus_en = (en_div != 0) && (phase % en_div == 0);
      if (bus_req) begin
         wait_cnt++;
         bus_ack = (wait_cnt > lat);
      end else begin
         wait_cnt = 0;
         bus_ack = 1'b0;
      end
      if (bus_req && bus_ack && !bus_en) begin
         ign_pending = 1'b1;
         ign_addr = bus_addr;
      end
      if (bus_req && bus_ack && bus_en) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R7 unexpected transfer", {96'b0, bus_addr}, 128'b0);
         end else begin
            item_t e;
            string t;
            e = sb.pop_front();
            t = sb_tag.pop_front();
            chk(bus_is_line == e.is_line && bus_addr == e.addr, {t, " addr/kind"},
                {95'b0, bus_is_line, bus_addr}, {95'b0, e.is_line, e.addr});
            if (e.is_line)
               chk(bus_line == e.data, {t, " line data"}, bus_line, e.data);
            else
               chk(bus_data == e.data[31:0] && bus_be == e.be, {t, " word data"},
                   {92'b0, bus_be, bus_data}, {92'b0, e.be, e.data[31:0]});
         end
         wait_cnt = 0;
         lat = (lat + 1) % 4;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(!bus_req, "R10 bus_req", {127'b0, bus_req}, 0);
      chk(!wr_stall, "R10 wr_stall", {127'b0, wr_stall}, 0);
      chk(!ev_full, "R10 ev_full", {127'b0, ev_full}, 0);
      chk(!rd_hazard, "R10 rd_hazard", {127'b0, rd_hazard}, 0);

      // Bus stalled: four writes on consecutive clocks (R1, R2)
      en_div = 0;
      for (int i = 0; i < 4; i++) begin
         chk(!wr_stall, "R2 accepts each clock", {127'b0, wr_stall}, 0);
         do_write(32'h0000_1000 + 32'(i * 32), 32'hA000_0000 + 32'(i), 4'hF, 1'b1);
      end
      chk(wr_stall, "R1 four entries held, R3 stall", {127'b0, wr_stall}, 1);
      chk(!bus_req, "R5 no request without enable", {127'b0, bus_req}, 0);
      rd_addr = 32'h0000_1041;
      #1 chk(rd_hazard, "R9 word hazard", {127'b0, rd_hazard}, 1);
      rd_addr = 32'h0000_1044;
      #1 chk(!rd_hazard, "R9 neighbour word", {127'b0, rd_hazard}, 0);
      // Fifth write held under stall (R3)
      wr_valid = 1'b1; wr_addr = 32'h0000_2000; wr_data = 32'hA000_0004; wr_be = 4'h3;
      repeat (3) @(negedge clk);
      chk(wr_stall && !bus_req, "R3 write held", {126'b0, wr_stall, bus_req}, 2);
      en_div = 4;
      while (wr_stall) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      expect_word(32'h0000_2000, 32'hA000_0004, 4'h3, "R3 held write");
      drain_wait();
      rd_addr = 32'h0000_1040;
      #1 chk(!rd_hazard, "R9 hazard cleared", {127'b0, rd_hazard}, 0);

      // Line conflicting with a queued store goes first (R8)
      en_div = 0;
      do_evict(32'h0000_0100, {32'hC3, 32'hC2, 32'hC1, 32'hC0});
      do_write(32'h0000_0200, 32'hB000_0001, 4'hF, 1'b0);
      do_write(32'h0000_0104, 32'hB000_0002, 4'h1, 1'b0);
      expect_line(32'h0000_0100, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, "R8 conflict line");
      expect_word(32'h0000_0200, 32'hB000_0001, 4'hF, "R8 after line");
      expect_word(32'h0000_0104, 32'hB000_0002, 4'h1, "R8 same-line store");
      rd_addr = 32'h0000_010C;
      #1 chk(rd_hazard, "R9 line hazard", {127'b0, rd_hazard}, 1);
      en_div = 2;
      drain_wait();
      rd_addr = 32'h0000_010C;
      #1 chk(!rd_hazard, "R9 line hazard cleared", {127'b0, rd_hazard}, 0);

      // No conflict: stores go before the line (R8, R4)
      en_div = 0;
      do_evict(32'h0000_0300, {32'hD3, 32'hD2, 32'hD1, 32'hD0});
      chk(ev_full, "R4 line held", {127'b0, ev_full}, 1);
      do_write(32'h0000_0400, 32'hB000_0003, 4'hF, 1'b0);
      do_write(32'h0000_0500, 32'hB000_0004, 4'hC, 1'b0);
      expect_word(32'h0000_0400, 32'hB000_0003, 4'hF, "R8 store first");
      expect_word(32'h0000_0500, 32'hB000_0004, 4'hC, "R8 store second");
      expect_line(32'h0000_0300, {32'hD3, 32'hD2, 32'hD1, 32'hD0}, "R8 line last");
      en_div = 4;
      drain_wait();

      // Back-to-back evictions: second held until first leaves (R4)
      en_div = 2;
      expect_line(32'h0000_0600, {4{32'hE0E0_0001}}, "R4 first line");
      expect_line(32'h0000_0700, {4{32'hE0E0_0002}}, "R4 second line");
      do_evict(32'h0000_0600, {4{32'hE0E0_0001}});
      chk(ev_full, "R4 full after load", {127'b0, ev_full}, 1);
      do_evict(32'h0000_0700, {4{32'hE0E0_0002}});
      drain_wait();

      // Streaming writes at half rate with natural stalls (R7, R5)
      for (int i = 0; i < 10; i++)
         do_write(32'h0000_8000 + 32'(i * 4), 32'h5500_0000 + 32'(i * 17),
                  4'(i + 1), 1'b1);
      drain_wait();
      // Same stream at quarter rate
      en_div = 4;
      for (int i = 0; i < 6; i++)
         do_write(32'h0000_9000 + 32'(i * 16), 32'h6600_0000 + 32'(i), 4'hF, 1'b1);
      drain_wait();
      chk(!bus_req && !wr_stall, "R5 idle after drains", {126'b0, bus_req, wr_stall}, 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule